// File: doc/BRIEF.md
# Nibble-Command Register Access Port

This block sits behind a host byte channel and turns a stream of 8-bit command bytes into reads and writes of a 256-entry, 8-bit register space. Each byte holds a 4-bit opcode in its upper half and a 4-bit operand in its lower half. The host builds a register address from two nibble commands, and a write data byte from a low-nibble command followed by a high-nibble command. The high-nibble command is also the one that commits the write. A read command fetches the byte at the current address. It sends that byte back on a response channel and can then move the address one step up or down, so that a block of registers can be read as a burst.

The register storage is outside this block. The port drives a write strobe with address and data. It also drives a read strobe with an address and takes the read byte back in the same cycle. Reads and writes use separate strobes, so the same address can map to different functions for each direction.

Top module: `nibcmd_regport`

## Requirements
- R1: A command byte is decoded as opcode = bits 7:4 and operand = bits 3:0. Opcode 0x0 loads the operand into address bits 3:0 and opcode 0x1 loads it into address bits 7:4. The other address nibble is kept. At most one of the read and write strobes is high in any cycle.
- R2: Opcode 0x2 stores the operand as the low data nibble. The stored nibble stays until the next accepted 0x2, so several 0x3 commands can reuse it.
- R3: Opcode 0x3 raises `reg_wr_en` for exactly the cycle in which it is accepted. In that cycle `reg_wr_addr` is the current address and `reg_wr_data` is {operand, stored low nibble}.
- R4: Opcode 0x4 raises `reg_rd_en` in its accept cycle, with `reg_rd_addr` equal to the current address. In the next cycle `rsp_valid` is 1 and `rsp_data` holds the `reg_rd_data` sampled at that edge.
- R5: For opcode 0x4, operand bit 0 = 1 adjusts the address after the access. Operand bit 1 = 1 makes the adjust a decrement and 0 makes it an increment. With bit 0 = 0 the address does not change, whatever bit 1 is.
- R6: An address adjust wraps modulo 256: an increment from 0xFF gives 0x00 and a decrement from 0x00 gives 0xFF.
- R7: `rsp_valid` is 1 exactly in the cycle after each accepted read and is 0 otherwise. Back-to-back reads give back-to-back strobes.
- R8: `cmd_ready` equals `rsp_ready`. While `rsp_ready` is 0 no command is accepted: there are no strobes, no response, and the address and data state stay the same.
- R9: Opcodes 0x5 to 0xF are accepted but do nothing. They raise no strobe and leave the address and the stored low nibble unchanged.
- R10: After reset the address is 0x00, the stored low nibble is 0x0, and `rsp_valid`, `reg_wr_en` and `reg_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Opcode (7:4) and operand (3:0) |
| cmd_ready | output | 1 | Command is taken this cycle when valid |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 8 | Write address |
| reg_wr_data | output | 8 | Write data |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rd_addr | output | 8 | Read address |
| reg_rd_data | input | 8 | Read byte returned in the same cycle |
| rsp_ready | input | 1 | Response channel can take a byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 8 | Response byte |

## Verification
The bench builds the port with the default nibble width of 4, which gives an 8-bit address and 256 registers. With that width, a few address-nibble commands are enough to reach both ends of the address space. The bench places the address at 0xFF and 0x00 to check the increment and decrement wrap. It also models a full 256-entry register file of its own, so every read-back value comes from the bench's own storage and not from the design.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;

  localparam logic [3:0] OPC_ADDR_LO = 4'h0;
  localparam logic [3:0] OPC_ADDR_HI = 4'h1;
  localparam logic [3:0] OPC_DATA_LO = 4'h2;
  localparam logic [3:0] OPC_WR_GO   = 4'h3;
  localparam logic [3:0] OPC_RD_GO   = 4'h4;

  localparam int unsigned STEP_EN_BIT  = 0;
  localparam int unsigned STEP_DIR_BIT = 1;

  typedef struct packed {
    logic ld_alo;
    logic ld_ahi;
    logic ld_dlo;
    logic wr_go;
    logic rd_go;
  } nib_strobe_t;

endpackage

// File: rtl/nibcmd_decode.sv
module nibcmd_decode
  import nibcmd_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [2*NIB_W-1:0]   cmd_byte,
  output nib_strobe_t          strobe,
  output logic [NIB_W-1:0]     operand
);

  localparam int unsigned CMD_W = 2 * NIB_W;

  logic [NIB_W-1:0] opcode;
  logic             foreign_op;

  assign opcode  = cmd_byte[CMD_W-1 -: NIB_W];
  assign operand = cmd_byte[NIB_W-1:0];

  always_comb begin
    strobe        = '0;
    strobe.ld_alo = accept && (opcode == NIB_W'(OPC_ADDR_LO));
    strobe.ld_ahi = accept && (opcode == NIB_W'(OPC_ADDR_HI));
    strobe.ld_dlo = accept && (opcode == NIB_W'(OPC_DATA_LO));
    strobe.wr_go  = accept && (opcode == NIB_W'(OPC_WR_GO));
    strobe.rd_go  = accept && (opcode == NIB_W'(OPC_RD_GO));
  end

  assign foreign_op = opcode > NIB_W'(OPC_RD_GO);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe)); // R1

  AST_FOREIGN_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && foreign_op) |-> (strobe == '0)); // R9

endmodule

// File: rtl/nibcmd_addr.sv
module nibcmd_addr
  import nibcmd_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [NIB_W-1:0]    nib,
  input  logic                step_en,
  input  logic                step_down,
  output logic [2*NIB_W-1:0]  addr_q
);

  localparam int unsigned ADDR_W = 2 * NIB_W;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic down);
    step_addr = down ? (a - ADDR_W'(1)) : (a + ADDR_W'(1));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ld_lo) begin
      addr_q[NIB_W-1:0] <= nib;
    end else if (ld_hi) begin
      addr_q[ADDR_W-1:NIB_W] <= nib;
    end else if (step_en) begin
      addr_q <= step_addr(addr_q, step_down);
    end
  end

  AST_ADDR_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_down && addr_q == '1) |=> (addr_q == '0)); // R6

  AST_ADDR_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_down && addr_q == '0) |=> (addr_q == '1)); // R6

  AST_ADDR_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (addr_q[ADDR_W-1:NIB_W] == $past(addr_q[ADDR_W-1:NIB_W]))); // R1

  AST_ADDR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_lo && !ld_hi && !step_en) |=> $stable(addr_q)); // R5

endmodule

// File: rtl/nibcmd_wdata.sv
module nibcmd_wdata #(
  parameter int unsigned NIB_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_lo,
  input  logic [NIB_W-1:0]    nib,
  output logic [2*NIB_W-1:0]  wr_data
);

  logic [NIB_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     lo_q <= '0;
    else if (ld_lo) lo_q <= nib;
  end

  assign wr_data = {nib, lo_q};

  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_lo |=> $stable(lo_q)); // R2

endmodule

// File: rtl/nibcmd_rsp.sv
module nibcmd_rsp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_data <= rd_data;
    end
  end

endmodule

// File: rtl/nibcmd_regport.sv
module nibcmd_regport
  import nibcmd_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2*NIB_W-1:0] cmd_byte,
  output logic               cmd_ready,
  output logic               reg_wr_en,
  output logic [2*NIB_W-1:0] reg_wr_addr,
  output logic [2*NIB_W-1:0] reg_wr_data,
  output logic               reg_rd_en,
  output logic [2*NIB_W-1:0] reg_rd_addr,
  input  logic [2*NIB_W-1:0] reg_rd_data,
  input  logic               rsp_ready,
  output logic               rsp_valid,
  output logic [2*NIB_W-1:0] rsp_data
);

  localparam int unsigned BYTE_W = 2 * NIB_W;

  logic              accept;
  nib_strobe_t       strobe;
  logic [NIB_W-1:0]  operand;
  logic [BYTE_W-1:0] addr_q;
  logic              step_en;
  logic              step_down;

  assign cmd_ready = rsp_ready;
  assign accept    = cmd_valid && rsp_ready;

  nibcmd_decode #(.NIB_W(NIB_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .cmd_byte (cmd_byte),
    .strobe   (strobe),
    .operand  (operand)
  );

  assign step_en   = strobe.rd_go && operand[STEP_EN_BIT];
  assign step_down = operand[STEP_DIR_BIT];

  nibcmd_addr #(.NIB_W(NIB_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_lo     (strobe.ld_alo),
    .ld_hi     (strobe.ld_ahi),
    .nib       (operand),
    .step_en   (step_en),
    .step_down (step_down),
    .addr_q    (addr_q)
  );

  nibcmd_wdata #(.NIB_W(NIB_W)) u_wdata (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (strobe.ld_dlo),
    .nib     (operand),
    .wr_data (reg_wr_data)
  );

  assign reg_wr_en   = strobe.wr_go;
  assign reg_wr_addr = addr_q;
  assign reg_rd_en   = strobe.rd_go;
  assign reg_rd_addr = addr_q;

  nibcmd_rsp #(.DATA_W(BYTE_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_go     (strobe.rd_go),
    .rd_data   (reg_rd_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en)); // R1

  AST_WR_HIGH_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_wr_data[BYTE_W-1:NIB_W] == cmd_byte[NIB_W-1:0])); // R3

  AST_READ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> (rsp_valid && rsp_data == $past(reg_rd_data))); // R4

  AST_RSP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(reg_rd_en)); // R7

  AST_NO_ACCESS_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |-> (!reg_rd_en && !reg_wr_en)); // R8

  AST_ADDR_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready) |=> $stable(reg_rd_addr)); // R8

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && cmd_byte[0] && !cmd_byte[1]) |=>
      (reg_rd_addr == $past(reg_rd_addr) + BYTE_W'(1))); // R5

endmodule

// File: tb/nibcmd_regport_tb.sv
`timescale 1ns/1ps
module nibcmd_regport_tb;

  typedef struct packed {
    logic [7:0] cmd;
    logic       rv;
    logic [7:0] rd;
    logic       wv;
    logic [7:0] wa;
    logic [7:0] wd;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{8'h05, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h2C, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h3A, 1'b0, 8'h00, 1'b1, 8'h15, 8'hAC},
    '{8'h40, 1'b1, 8'hAC, 1'b0, 8'h00, 8'h00},
    '{8'h41, 1'b1, 8'hAC, 1'b0, 8'h00, 8'h00},
    '{8'h41, 1'b1, 8'hE9, 1'b0, 8'h00, 8'h00},
    '{8'h43, 1'b1, 8'hE8, 1'b0, 8'h00, 8'h00},
    '{8'h40, 1'b1, 8'hE9, 1'b0, 8'h00, 8'h00},
    '{8'h0F, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h1F, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h3B, 1'b0, 8'h00, 1'b1, 8'hFF, 8'hBC},
    '{8'h41, 1'b1, 8'hBC, 1'b0, 8'h00, 8'h00},
    '{8'h40, 1'b1, 8'h50, 1'b0, 8'h00, 8'h00},
    '{8'h43, 1'b1, 8'h50, 1'b0, 8'h00, 8'h00},
    '{8'h40, 1'b1, 8'hBC, 1'b0, 8'h00, 8'h00},
    '{8'h75, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    '{8'hF3, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h40, 1'b1, 8'hBC, 1'b0, 8'h00, 8'h00},
    '{8'h42, 1'b1, 8'hBC, 1'b0, 8'h00, 8'h00},
    '{8'h40, 1'b1, 8'hBC, 1'b0, 8'h00, 8'h00},
    '{8'h2D, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h52, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h31, 1'b0, 8'h00, 1'b1, 8'hFF, 8'h1D},
    '{8'h40, 1'b1, 8'h1D, 1'b0, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       cmd_ready;
  logic       reg_wr_en;
  logic [7:0] reg_wr_addr;
  logic [7:0] reg_wr_data;
  logic       reg_rd_en;
  logic [7:0] reg_rd_addr;
  logic [7:0] reg_rd_data;
  logic       rsp_ready = 1'b1;
  logic       rsp_valid;
  logic [7:0] rsp_data;

  logic [7:0] mem [256];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nibcmd_regport u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_byte    (cmd_byte),
    .cmd_ready   (cmd_ready),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_addr (reg_rd_addr),
    .reg_rd_data (reg_rd_data),
    .rsp_ready   (rsp_ready),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );

  // bench register file, reset to 0xFF - index
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(8'hFF - i);
    end else if (reg_wr_en) begin
      mem[reg_wr_addr] <= reg_wr_data;
    end
  end
  assign reg_rd_data = mem[reg_rd_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one command during a cycle, check strobes, then check response
  task automatic step(input vec_t v, input string req);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = v.cmd;
    #1;
    chk({req, " wr_en"}, 32'(reg_wr_en), 32'(v.wv));
    if (v.wv) begin
      chk({req, " wr_addr"}, 32'(reg_wr_addr), 32'(v.wa));
      chk({req, " wr_data"}, 32'(reg_wr_data), 32'(v.wd));
    end
    chk({req, " rd_en"}, 32'(reg_rd_en), 32'(v.rv));
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'(v.rv));
    if (v.rv) chk({req, " rsp_data"}, 32'(rsp_data), 32'(v.rd));
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: idle outputs after reset
    chk("R10 rsp_valid", 32'(rsp_valid), 0);
    chk("R10 wr_en", 32'(reg_wr_en), 0);
    chk("R10 rd_en", 32'(reg_rd_en), 0);
    chk("R8 ready", 32'(cmd_ready), 1);
    // R10: address zero, read mem[0] = 0xFF
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = 8'h40;
    #1 chk("R10 rd_addr", 32'(reg_rd_addr), 32'h00);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 rsp_data", 32'(rsp_data), 32'hFF);
    // R10: low nibble zero -> 0x35 writes 0x50 to 0x00
    step('{8'h35, 1'b0, 8'h00, 1'b1, 8'h00, 8'h50}, "R10");

    // table: R1 R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) step(TBL[i], $sformatf("R1-table[%0d]", i));

    // R8: stalled response channel, address is 0xFF
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_byte = 8'h41;
    #1;
    chk("R8 cmd_ready low", 32'(cmd_ready), 0);
    chk("R8 no rd_en", 32'(reg_rd_en), 0);
    @(negedge clk);
    cmd_byte = 8'h05;
    chk("R8 no rsp", 32'(rsp_valid), 0);
    #1 chk("R8 no wr_en", 32'(reg_wr_en), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    // address must still be 0xFF after the stall
    step('{8'h40, 1'b1, 8'h1D, 1'b0, 8'h00, 8'h00}, "R8 after stall");

    // R7: back-to-back reads give back-to-back strobes, then drop
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = 8'h41;
    @(negedge clk);
    cmd_byte = 8'h40;
    chk("R7 first rsp_valid", 32'(rsp_valid), 1);
    chk("R7 first rsp_data", 32'(rsp_data), 32'h1D);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 second rsp_valid", 32'(rsp_valid), 1);
    chk("R6 R7 second rsp_data", 32'(rsp_data), 32'h50);
    @(negedge clk);
    chk("R7 strobe drops", 32'(rsp_valid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule